// File: doc/BRIEF.md
# FFT Output Reorder Buffer

A radix-2 decimation-in-frequency pipeline produces its frequency bins in bit-reversed order: the j-th result to leave the last stage is bin X[rev(j)], where rev() mirrors the bits of the index. This block sits behind that last stage and restores natural order. It does not sort. Each arriving complex sample is written straight into the slot of a storage bank that matches its true frequency index. Once a bank holds a whole transform, the block streams X[0] through X[N-1] out, one bin per cycle.

Storage is split into two banks that alternate. While one bank is being read out, the next transform is written into the other one. Back-to-back transforms therefore flow through with no stall and no gap in the output. Each input component is the 16 most significant bits of the last butterfly stage's output. The block stores and returns these bits unchanged. The default configuration is a 32-point transform.

Top module: `fft_reorder_buf`

## Requirements
- R1: After reset, out_valid and out_done are 0 and out_re and out_im are 0.
- R2: Input samples are counted only on cycles with in_valid high. Within a transform, the j-th counted sample (j = 0 to 31) carries bin X[rev5(j)], where rev5(j) mirrors the 5 bits of j (bit 0 swaps with bit 4, bit 1 swaps with bit 3). The k-th output of that transform is bin X[k], for k = 0 to 31.
- R3: Each output component equals the 16-bit signed input component it came from, bit for bit. The real part appears on out_re and the imaginary part on out_im, with no swap and no scaling.
- R4: When the reader is idle, X[0] is presented in the second cycle after the clock edge that captures the 32nd sample. out_valid then stays high for exactly 32 consecutive cycles.
- R5: out_done is high for exactly one cycle, in the cycle right after the cycle that presents X[31].
- R6: Cycles with in_valid low, whatever the data inputs carry, neither advance the arrival count nor change any stored or output value.
- R7: Writes alternate between two banks. A transform whose 32nd sample is captured while the previous transform is still being read out is emitted directly after it: its X[0] follows the previous X[31] in the next cycle.
- R8: A transform with fewer than 32 captured samples produces no output. out_valid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is present on in_re/in_im this cycle |
| in_re | input | DATA_W (16) | Real part of the arriving bin, signed |
| in_im | input | DATA_W (16) | Imaginary part of the arriving bin, signed |
| out_valid | output | 1 | out_re/out_im hold a bin in natural order |
| out_re | output | DATA_W (16) | Real part of the current output bin |
| out_im | output | DATA_W (16) | Imaginary part of the current output bin |
| out_done | output | 1 | One-cycle pulse after the last bin of a transform |

## Verification
Each test sample carries its own transform number and frequency index in its real part. Because of this, a wrong write address or a stale bank selection shows up as a mismatched value on the very first affected output cycle. If the arrival counter or a bank's full flag goes wrong, the symptoms at the ports are different. The output starts one or more cycles early or late, a gap opens between two streamed transforms, the done pulse misses its position after X[31], or output appears for a partial transform. All of these are caught within one transform period of the fault. Transforms are sent contiguously, with idle gaps carrying junk data, and back to back, and the bench ends with a truncated transform.

// File: rtl/fftro_pkg.sv
package fftro_pkg;
   // Identifies one of the two alternating storage banks.
   typedef enum logic [0:0] {
      BANK_A = 1'b0,
      BANK_B = 1'b1
   } bank_t;

   function automatic bank_t other_bank(input bank_t b);
      return (b == BANK_A) ? BANK_B : BANK_A;
   endfunction
endpackage

// File: rtl/fftro_bitrev.sv
module fftro_bitrev #(
   parameter int W = 5
) (
   input  logic [W-1:0] idx_i,
   output logic [W-1:0] rev_o
);
   if (W < 1) begin : g_bad_w
      $error("fftro_bitrev: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_mirror
      assign rev_o[i] = idx_i[W-1-i];
   end
endmodule

// File: rtl/fftro_wr_seq.sv
module fftro_wr_seq
   import fftro_pkg::*;
#(
   parameter int LOG2N = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             wr_en,
   output bank_t            wr_bank,
   output logic [LOG2N-1:0] wr_addr,
   output logic             fill,
   output bank_t            fill_bank
);
   localparam logic [LOG2N-1:0] LAST_IDX = '1;

   logic [LOG2N-1:0] arr_cnt_q;
   bank_t            bank_q;

   // Destination slot is the mirrored arrival count.
   fftro_bitrev #(.W(LOG2N)) u_rev (
      .idx_i (arr_cnt_q),
      .rev_o (wr_addr)
   );

   assign wr_en     = in_valid;
   assign wr_bank   = bank_q;
   assign fill      = in_valid && (arr_cnt_q == LAST_IDX);
   assign fill_bank = bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arr_cnt_q <= '0;
         bank_q    <= BANK_A;
      end else if (in_valid) begin
         arr_cnt_q <= arr_cnt_q + LOG2N'(1);
         if (arr_cnt_q == LAST_IDX) begin
            bank_q <= other_bank(bank_q);
         end
      end
   end

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(arr_cnt_q) && $stable(bank_q));

   // R7
   bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill |=> (bank_q != $past(bank_q)) && (arr_cnt_q == '0));
endmodule

// File: rtl/fftro_bank_mem.sv
module fftro_bank_mem
   import fftro_pkg::*;
#(
   parameter int LOG2N  = 5,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              wr_en,
   input  bank_t             wr_bank,
   input  logic [LOG2N-1:0]  wr_addr,
   input  logic [WORD_W-1:0] wr_word,
   input  bank_t             rd_bank,
   input  logic [LOG2N-1:0]  rd_addr,
   output logic [WORD_W-1:0] rd_word
);
   localparam int DEPTH = 1 << LOG2N;
   localparam int BANKS = 2;

   logic [WORD_W-1:0] bank_rd [BANKS];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [WORD_W-1:0] slot_q [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == bank_t'(b))) begin
            slot_q[wr_addr] <= wr_word;
         end
      end

      assign bank_rd[b] = slot_q[rd_addr];
   end

   assign rd_word = bank_rd[rd_bank];
endmodule

// File: rtl/fftro_rd_seq.sv
module fftro_rd_seq
   import fftro_pkg::*;
#(
   parameter int LOG2N = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill,
   input  bank_t            fill_bank,
   output logic             rd_en,
   output bank_t            rd_bank,
   output logic [LOG2N-1:0] rd_addr,
   output logic             rd_last
);
   localparam logic [LOG2N-1:0] LAST_IDX = '1;
   localparam int BANKS = 2;

   logic [BANKS-1:0] full_q;
   logic             active_q;
   bank_t            bank_q;
   logic [LOG2N-1:0] addr_q;
   logic             start_idle;

   assign rd_en      = active_q;
   assign rd_bank    = bank_q;
   assign rd_addr    = addr_q;
   assign rd_last    = active_q && (addr_q == LAST_IDX);
   assign start_idle = !active_q && full_q[bank_q];

   // Per-bank full flags: set by the writer, cleared after the last read.
   for (genvar b = 0; b < BANKS; b++) begin : g_full
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full_q[b] <= 1'b0;
         end else if (fill && (fill_bank == bank_t'(b))) begin
            full_q[b] <= 1'b1;
         end else if (rd_last && (bank_q == bank_t'(b))) begin
            full_q[b] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         bank_q   <= BANK_A;
         addr_q   <= '0;
      end else if (start_idle) begin
         active_q <= 1'b1;
         addr_q   <= '0;
      end else if (rd_last) begin
         bank_q   <= other_bank(bank_q);
         active_q <= full_q[other_bank(bank_q)];
         addr_q   <= '0;
      end else if (active_q) begin
         addr_q   <= addr_q + LOG2N'(1);
      end
   end

   // R7
   no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill |-> !full_q[fill_bank]);

   // R8
   read_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> full_q[bank_q]);

   // R4
   read_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !rd_last) |=> active_q && (addr_q == $past(addr_q) + LOG2N'(1)));
endmodule

// File: rtl/fft_reorder_buf.sv
module fft_reorder_buf
   import fftro_pkg::*;
#(
   parameter int LOG2N  = 5,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_re,
   input  logic [DATA_W-1:0] in_im,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_re,
   output logic [DATA_W-1:0] out_im,
   output logic              out_done
);
   localparam int WORD_W = 2 * DATA_W;

   if (LOG2N < 1 || LOG2N > 10) begin : g_bad_log2n
      $error("fft_reorder_buf: LOG2N must lie in 1..10");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("fft_reorder_buf: DATA_W must be at least 1");
   end

   logic              wr_en;
   bank_t             wr_bank;
   logic [LOG2N-1:0]  wr_addr;
   logic              fill;
   bank_t             fill_bank;
   logic              rd_en;
   bank_t             rd_bank;
   logic [LOG2N-1:0]  rd_addr;
   logic              rd_last;
   logic [WORD_W-1:0] rd_word;
   logic              last_q;

   fftro_wr_seq #(.LOG2N(LOG2N)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .wr_en     (wr_en),
      .wr_bank   (wr_bank),
      .wr_addr   (wr_addr),
      .fill      (fill),
      .fill_bank (fill_bank)
   );

   fftro_bank_mem #(.LOG2N(LOG2N), .WORD_W(WORD_W)) u_mem (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_bank (wr_bank),
      .wr_addr (wr_addr),
      .wr_word ({in_re, in_im}),
      .rd_bank (rd_bank),
      .rd_addr (rd_addr),
      .rd_word (rd_word)
   );

   fftro_rd_seq #(.LOG2N(LOG2N)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill      (fill),
      .fill_bank (fill_bank),
      .rd_en     (rd_en),
      .rd_bank   (rd_bank),
      .rd_addr   (rd_addr),
      .rd_last   (rd_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
         last_q    <= 1'b0;
         out_done  <= 1'b0;
      end else begin
         out_valid <= rd_en;
         last_q    <= rd_last;
         out_done  <= last_q;
         if (rd_en) begin
            {out_re, out_im} <= rd_word;
         end
      end
   end

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |=> !out_done);

   // R5
   done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_done) |-> $past(out_valid));

   // R4
   valid_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !last_q) |=> out_valid);
endmodule

// File: tb/tb_fft_reorder_buf.sv
module tb_fft_reorder_buf;
   localparam int LOG2N  = 5;
   localparam int N      = 32;
   localparam int DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [DATA_W-1:0] in_re = '0;
   logic [DATA_W-1:0] in_im = '0;
   logic              out_valid;
   logic [DATA_W-1:0] out_re;
   logic [DATA_W-1:0] out_im;
   logic              out_done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   fft_reorder_buf #(.LOG2N(LOG2N), .DATA_W(DATA_W)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_re     (in_re),
      .in_im     (in_im),
      .out_valid (out_valid),
      .out_re    (out_re),
      .out_im    (out_im),
      .out_done  (out_done)
   );

   function automatic int rev5(input int j);
      int r = 0;
      for (int b = 0; b < LOG2N; b++) begin
         if (((j >> b) & 1) != 0) r |= 1 << (LOG2N - 1 - b);
      end
      return r;
   endfunction

   // Real part tags transform number (upper byte) and bin index (low bits).
   function automatic logic [DATA_W-1:0] gen_re(input int fr, input int k);
      return DATA_W'((fr << 8) | k);
   endfunction

   // Imaginary part is negative and differs per bin.
   function automatic logic [DATA_W-1:0] gen_im(input int fr, input int k);
      return DATA_W'(0) - gen_re(fr, k) - DATA_W'(3 * k + 1);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Bench-side arrival bookkeeping.
   int cyc = 0;
   int arr = 0;
   int cur_fr = 0;
   int fill_cyc [8];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && in_valid) begin
         if (arr == N - 1) begin
            fill_cyc[cur_fr] <= cyc + 1;
            cur_fr <= cur_fr + 1;
         end
         arr <= (arr + 1) % N;
      end
   end

   // Output monitor.
   int mon_fr = 0;
   int mon_k = 0;
   int prev_cyc = 0;
   int last31_cyc = 0;
   int total_out = 0;
   int done_cnt = 0;
   bit done_exp = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_done || done_exp)
            check(out_done == done_exp, "R5", "out_done", int'(out_done), int'(done_exp));
         if (out_done) done_cnt++;
         done_exp = out_valid && (mon_k == N - 1);
         if (out_valid) begin
            total_out++;
            if (mon_fr >= 4) begin
               check(1'b0, "R8", "output from partial transform", int'(out_re), 0);
            end else begin
               check(out_re == gen_re(mon_fr, mon_k), (mon_fr == 1) ? "R6" : "R2",
                     $sformatf("re fr=%0d k=%0d", mon_fr, mon_k),
                     int'(out_re), int'(gen_re(mon_fr, mon_k)));
               check(out_im == gen_im(mon_fr, mon_k), "R3",
                     $sformatf("im fr=%0d k=%0d", mon_fr, mon_k),
                     int'(out_im), int'(gen_im(mon_fr, mon_k)));
               if (mon_k == 0) begin
                  check(cyc - fill_cyc[mon_fr] == 2, "R4", "X[0] latency",
                        cyc - fill_cyc[mon_fr], 2);
                  if (mon_fr == 3)
                     check(cyc - last31_cyc == 1, "R7", "back-to-back gap",
                           cyc - last31_cyc, 1);
               end else begin
                  check(cyc == prev_cyc + 1, "R4", "contiguous valid", cyc, prev_cyc + 1);
               end
            end
            prev_cyc = cyc;
            if (mon_k == N - 1) begin
               mon_k = 0;
               mon_fr++;
               last31_cyc = cyc;
            end else begin
               mon_k++;
            end
         end
      end
   end

   // Sends one transform in pipeline order; leaves in_valid high at the end.
   task automatic send_frame(input int fr, input bit gaps);
      for (int j = 0; j < N; j++) begin
         if (gaps && (j % 3 == 2)) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_re = 16'hFFFF;
            in_im = DATA_W'(16'h5A00 + j);
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_re = gen_re(fr, rev5(j));
         in_im = gen_im(fr, rev5(j));
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      in_valid = 1'b0;
      in_re = 16'hDEAD;
      in_im = 16'hBEEF;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
      check(out_done == 1'b0, "R1", "out_done", int'(out_done), 0);
      check(out_re == '0, "R1", "out_re", int'(out_re), 0);
      check(out_im == '0, "R1", "out_im", int'(out_im), 0);

      // R2, R3, R4, R5: single contiguous transform
      send_frame(0, 1'b0);
      go_idle();
      while (done_cnt < 1) @(negedge clk);

      // R6: transform with idle gaps carrying junk
      send_frame(1, 1'b1);
      go_idle();
      while (done_cnt < 2) @(negedge clk);

      // R7: two transforms back to back
      send_frame(2, 1'b0);
      send_frame(3, 1'b0);
      go_idle();
      while (done_cnt < 4) @(negedge clk);
      repeat (4) @(negedge clk);

      // R8: partial transform must produce nothing
      for (int j = 0; j < 10; j++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_re = gen_re(4, rev5(j));
         in_im = gen_im(4, rev5(j));
      end
      go_idle();
      repeat (80) @(negedge clk);
      check(total_out == 4 * N, "R8", "total outputs", total_out, 4 * N);
      check(done_cnt == 4, "R5", "done pulses", done_cnt, 4);
      check(out_valid == 1'b0, "R8", "out_valid after partial", int'(out_valid), 0);

      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R4 watchdog: actual=%0d expected=%0d", done_cnt, 4);
         summary();
         $finish;
      end
   end
endmodule